// File: doc/BRIEF.md
# Time Register Snapshot and Atomic Commit Buffer

This block sits between a byte-level serial register interface and a free-running time-of-day counter that holds eight time bytes. When the host starts reading the time, the block freezes a copy of all eight live bytes. Every byte returned to the host comes from that copy, so the host always sees one consistent time while the real counter keeps counting underneath.

When the host writes the time, each received byte is placed in a shadow buffer as it is acknowledged. Nothing reaches the live counter until the transfer closes with a stop, and then only if all eight bytes arrived and writes were enabled. A valid close raises a one-cycle load pulse that carries the whole shadow to the counter. The same pulse restarts the block's one-second prescaler, so the newly loaded time lasts a full second before its first increment. An abort, or a stop that ends an incomplete or disabled write, discards the staged bytes and leaves the live time as it was.

Top module: `rtc_snap_commit`

## Requirements
- R1: While reset is held, `loadPulse` and `secTick` are 0 and `rdData` reads 0 for every address.
- R2: An `ackEvt` with `rdMode`=1, outside an open read, captures `liveTime` at that clock edge. From the next cycle `rdData` equals the captured byte at `byteAddr`, where byte k is `liveTime[8k+7:8k]`.
- R3: While a read stays open, further read acknowledges and changes on `liveTime` leave `rdData` unchanged. A stop or abort closes the read, and the next read acknowledge captures again.
- R4: A written byte enters the shadow only at an `ackEvt` (with `rdMode`=0) that follows its `byteStrobe`. A byte that is strobed but not acknowledged never reaches `loadData`.
- R5: A stop that ends a write in which all eight addresses were acknowledged, with `wrEnable`=1 in the stop cycle, raises `loadPulse` for exactly one cycle, in the cycle after the stop. During that cycle `loadData` byte k holds the last value acknowledged for address k.
- R6: A stop that ends a write with any address missing produces no `loadPulse`, and it clears the record of received bytes. A later write must again supply all eight.
- R7: A stop with `wrEnable`=0 produces no `loadPulse`, even when all eight bytes were received.
- R8: `abortEvt` discards the staged write. Neither the abort nor a stop that follows it produces a `loadPulse`.
- R9: With no load, `secTick` pulses for one cycle every `TICK_DIV` cycles. After a `loadPulse` cycle, the next `secTick` comes exactly `TICK_DIV` cycles later.
- R10: `secTick` is 0 in any cycle in which `loadPulse` is 1, even when the prescaler is at its final count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdMode | input | 1 | 1 while the current transfer is a read, 0 for a write |
| byteStrobe | input | 1 | A write byte is present on `wrData` / `byteAddr` |
| ackEvt | input | 1 | Acknowledge event for the current byte |
| stopEvt | input | 1 | Stop condition ends the transfer |
| abortEvt | input | 1 | Transfer aborted (invalid sequence) |
| wrEnable | input | 1 | Write-enable condition, sampled at the stop |
| byteAddr | input | ADDR_W | Time byte index for read select and write target |
| wrData | input | 8 | Write byte value |
| liveTime | input | NBYTES*8 | Live time bytes from the counter |
| rdData | output | 8 | Snapshot byte at `byteAddr` |
| loadPulse | output | 1 | One-cycle load command to the counter |
| loadData | output | NBYTES*8 | Staged time bytes to load |
| secTick | output | 1 | One-second increment pulse for the counter |

## Verification
The commit load and the one-second tick can land in the same cycle. The bench first locks onto the free-running tick, then places the closing stop so that the load cycle falls exactly where the prescaler would reach its final count. In that cycle it requires `secTick` to be low. It then counts a full `TICK_DIV` cycles and accepts only a single tick, arriving at the end of that span. A capture acknowledge arriving while `liveTime` changes on every cycle is judged by reading every snapshot byte afterwards.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

  typedef enum logic [1:0] {
    XFER_IDLE  = 2'd0,
    XFER_READ  = 2'd1,
    XFER_WRITE = 2'd2
  } xferState_t;

  // strobes issued by the control unit to the datapath
  typedef struct packed {
    logic capture;    // freeze live time into snapshot
    logic holdLatch;  // take wrData/byteAddr into the holding register
    logic shadowWr;   // move held byte into the shadow buffer
    logic commit;     // valid end of write: request a load
  } snapStrobes_t;

endpackage

// File: rtl/rtc_snap_ctrl.sv
module rtc_snap_ctrl
  import rtc_snap_pkg::*;
#(
  parameter int NBYTES = 8,
  localparam int ADDR_W = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdMode,
  input  logic              byteStrobe,
  input  logic              ackEvt,
  input  logic              stopEvt,
  input  logic              abortEvt,
  input  logic              wrEnable,
  input  logic [ADDR_W-1:0] holdAddr,
  output snapStrobes_t      strobes
);

  xferState_t        state;
  logic [NBYTES-1:0] fillMask;
  logic              holdValid;
  logic              closing;
  logic              allFilled;

  assign closing   = stopEvt || abortEvt;
  assign allFilled = &fillMask;

  always_comb begin
    strobes           = '0;
    strobes.capture   = ackEvt && rdMode && (state != XFER_READ) && !closing;
    strobes.holdLatch = byteStrobe && !rdMode && !closing;
    strobes.shadowWr  = ackEvt && !rdMode && holdValid && !closing;
    strobes.commit    = stopEvt && !abortEvt && (state == XFER_WRITE)
                        && allFilled && wrEnable;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= XFER_IDLE;
    end else if (closing) begin
      state <= XFER_IDLE;
    end else if (strobes.capture) begin
      state <= XFER_READ;
    end else if (strobes.holdLatch) begin
      state <= XFER_WRITE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
    end else if (closing || strobes.shadowWr) begin
      holdValid <= 1'b0;
    end else if (strobes.holdLatch) begin
      holdValid <= 1'b1;
    end
  end

  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_fill
      always_ff @(posedge clk) begin
        if (!rstN) begin
          fillMask[b] <= 1'b0;
        end else if (closing) begin
          fillMask[b] <= 1'b0;
        end else if (strobes.shadowWr && (holdAddr == ADDR_W'(b))) begin
          fillMask[b] <= 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/rtc_snap_dp.sv
module rtc_snap_dp
  import rtc_snap_pkg::*;
#(
  parameter int NBYTES   = 8,
  parameter int TICK_DIV = 32768,
  localparam int ADDR_W = $clog2(NBYTES),
  localparam int TIME_W = NBYTES * 8,
  localparam int CNT_W  = $clog2(TICK_DIV)
) (
  input  logic              clk,
  input  logic              rstN,
  input  snapStrobes_t      strobes,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [7:0]        wrData,
  input  logic [TIME_W-1:0] liveTime,
  output logic [ADDR_W-1:0] holdAddr,
  output logic [7:0]        rdData,
  output logic              loadPulse,
  output logic [TIME_W-1:0] loadData,
  output logic              secTick,
  output logic [TIME_W-1:0] snapshotFlat
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  logic [7:0]       snapByte   [NBYTES];
  logic [7:0]       shadowByte [NBYTES];
  logic [7:0]       holdData;
  logic [CNT_W-1:0] preCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdAddr <= '0;
      holdData <= '0;
    end else if (strobes.holdLatch) begin
      holdAddr <= byteAddr;
      holdData <= wrData;
    end
  end

  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (!rstN) begin
          snapByte[b] <= '0;
        end else if (strobes.capture) begin
          snapByte[b] <= liveTime[b*8 +: 8];
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          shadowByte[b] <= '0;
        end else if (strobes.shadowWr && (holdAddr == ADDR_W'(b))) begin
          shadowByte[b] <= holdData;
        end
      end

      assign loadData[b*8 +: 8]     = shadowByte[b];
      assign snapshotFlat[b*8 +: 8] = snapByte[b];
    end
  endgenerate

  assign rdData = snapByte[byteAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadPulse <= 1'b0;
    end else begin
      loadPulse <= strobes.commit;
    end
  end

  // one-second prescaler, restarted by a load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (loadPulse || (preCnt == CNT_LAST)) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign secTick = (preCnt == CNT_LAST) && !loadPulse;

endmodule

// File: rtl/rtc_snap_commit.sv
module rtc_snap_commit
  import rtc_snap_pkg::*;
#(
  parameter int NBYTES   = 8,
  parameter int TICK_DIV = 32768,
  localparam int ADDR_W = $clog2(NBYTES),
  localparam int TIME_W = NBYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdMode,
  input  logic              byteStrobe,
  input  logic              ackEvt,
  input  logic              stopEvt,
  input  logic              abortEvt,
  input  logic              wrEnable,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [7:0]        wrData,
  input  logic [TIME_W-1:0] liveTime,
  output logic [7:0]        rdData,
  output logic              loadPulse,
  output logic [TIME_W-1:0] loadData,
  output logic              secTick
);

  snapStrobes_t      strobes;
  logic [ADDR_W-1:0] holdAddr;
  logic [TIME_W-1:0] snapshotFlat;

  rtc_snap_ctrl #(.NBYTES(NBYTES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rdMode     (rdMode),
    .byteStrobe (byteStrobe),
    .ackEvt     (ackEvt),
    .stopEvt    (stopEvt),
    .abortEvt   (abortEvt),
    .wrEnable   (wrEnable),
    .holdAddr   (holdAddr),
    .strobes    (strobes)
  );

  rtc_snap_dp #(.NBYTES(NBYTES), .TICK_DIV(TICK_DIV)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .byteAddr     (byteAddr),
    .wrData       (wrData),
    .liveTime     (liveTime),
    .holdAddr     (holdAddr),
    .rdData       (rdData),
    .loadPulse    (loadPulse),
    .loadData     (loadData),
    .secTick      (secTick),
    .snapshotFlat (snapshotFlat)
  );

endmodule

// File: rtl/rtc_snap_commit_chk.sv
module rtc_snap_commit_chk #(
  parameter int TIME_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopEvt,
  input logic              abortEvt,
  input logic              loadPulse,
  input logic              secTick,
  input logic              capture,
  input logic [TIME_W-1:0] liveTime,
  input logic [TIME_W-1:0] snapshotFlat
);

  // R5: load lasts exactly one cycle
  a_r5_load_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse |=> !loadPulse);

  // R5: load only follows a stop
  a_r5_load_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadPulse) |-> $past(stopEvt));

  // R8: an abort never yields a load
  a_r8_abort_no_load: assert property (@(posedge clk) disable iff (!rstN)
    abortEvt |=> !loadPulse);

  // R10: no tick in the load cycle
  a_r10_no_tick_on_load: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse |-> !secTick);

  // R9: prescaler restarts, so no tick right after a load
  a_r9_restart_after_load: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse |=> !secTick);

  // R2: snapshot holds what was live at the capture edge
  a_r2_capture_value: assert property (@(posedge clk) disable iff (!rstN)
    $past(capture) |-> (snapshotFlat == $past(liveTime)));

  // R3: snapshot frozen without a capture
  a_r3_snapshot_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !$past(capture) |-> $stable(snapshotFlat));

endmodule

bind rtc_snap_commit rtc_snap_commit_chk #(.TIME_W(TIME_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .stopEvt      (stopEvt),
  .abortEvt     (abortEvt),
  .loadPulse    (loadPulse),
  .secTick      (secTick),
  .capture      (strobes.capture),
  .liveTime     (liveTime),
  .snapshotFlat (snapshotFlat)
);

// File: tb/tb_rtc_snap_commit.sv
module tb_rtc_snap_commit;

  localparam int NB     = 8;
  localparam int DIV    = 16;
  localparam int AW     = $clog2(NB);
  localparam int TW     = NB * 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rdMode = 1'b0;
  logic          byteStrobe = 1'b0;
  logic          ackEvt = 1'b0;
  logic          stopEvt = 1'b0;
  logic          abortEvt = 1'b0;
  logic          wrEnable = 1'b0;
  logic [AW-1:0] byteAddr = '0;
  logic [7:0]    wrData = '0;
  logic [TW-1:0] liveTime = 64'h1122334455667788;
  logic [7:0]    rdData;
  logic          loadPulse;
  logic [TW-1:0] loadData;
  logic          secTick;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  rtc_snap_commit #(.NBYTES(NB), .TICK_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .rdMode(rdMode), .byteStrobe(byteStrobe),
    .ackEvt(ackEvt), .stopEvt(stopEvt), .abortEvt(abortEvt),
    .wrEnable(wrEnable), .byteAddr(byteAddr), .wrData(wrData),
    .liveTime(liveTime), .rdData(rdData), .loadPulse(loadPulse),
    .loadData(loadData), .secTick(secTick)
  );

  // {count[3:0], enable, abort, expectLoad}
  localparam logic [6:0] VEC [6] = '{
    {4'd8, 1'b1, 1'b0, 1'b1},   // R5 complete write
    {4'd7, 1'b1, 1'b0, 1'b0},   // R6 one byte missing
    {4'd8, 1'b0, 1'b0, 1'b0},   // R7 write disabled
    {4'd8, 1'b1, 1'b1, 1'b0},   // R8 aborted
    {4'd0, 1'b1, 1'b0, 1'b0},   // R6 stop with nothing
    {4'd8, 1'b1, 1'b0, 1'b1}    // R5 valid again after discards
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [TW-1:0] expImage(input logic [7:0] base);
    logic [TW-1:0] v;
    for (int i = 0; i < NB; i++) v[i*8 +: 8] = base + 8'(i);
    return v;
  endfunction

  task automatic sendBytes(input int first, input int count, input logic [7:0] base);
    rdMode = 1'b0;
    for (int i = first; i < first + count; i++) begin
      byteStrobe = 1'b1; byteAddr = AW'(i); wrData = base + 8'(i);
      cyc();
      byteStrobe = 1'b0; ackEvt = 1'b1;
      cyc();
      ackEvt = 1'b0;
    end
  endtask

  task automatic endWrite(input bit en, input bit abortIt);
    wrEnable = en;
    if (abortIt) abortEvt = 1'b1; else stopEvt = 1'b1;
    cyc();
    abortEvt = 1'b0; stopEvt = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    if (!done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] snapA;
    int tickAt;

    // reset: R1
    repeat (3) cyc();
    check(loadPulse == 1'b0, "R1 loadPulse in reset", 64'(loadPulse), 64'd0);
    check(secTick == 1'b0, "R1 secTick in reset", 64'(secTick), 64'd0);
    for (int i = 0; i < NB; i++) begin
      byteAddr = AW'(i); #1;
      check(rdData == 8'h00, "R1 rdData in reset", 64'(rdData), 64'd0);
    end
    rstN = 1'b1;
    cyc();

    // table of write transfers: R5 R6 R7 R8
    for (int k = 0; k < 6; k++) begin
      logic [7:0] base;
      int n;
      base = 8'h10 * 8'(k) + 8'h01;
      n = int'(VEC[k][6:3]);
      sendBytes(0, n, base);
      endWrite(VEC[k][2], VEC[k][1]);
      check(loadPulse == VEC[k][0], $sformatf("R5/R6/R7/R8 vec%0d load", k),
            64'(loadPulse), 64'(VEC[k][0]));
      if (VEC[k][0])
        check(loadData == expImage(base), $sformatf("R5 vec%0d loadData", k),
              loadData, expImage(base));
      cyc();
      check(loadPulse == 1'b0, $sformatf("R5 vec%0d pulse width", k), 64'(loadPulse), 64'd0);
      if (VEC[k][1]) begin
        endWrite(1'b1, 1'b0);   // R8 stop after abort
        check(loadPulse == 1'b0, "R8 stop after abort", 64'(loadPulse), 64'd0);
      end
    end

    // R6: received-byte record is cleared by a failed stop
    sendBytes(0, 4, 8'h30);
    endWrite(1'b1, 1'b0);
    check(loadPulse == 1'b0, "R6 half write", 64'(loadPulse), 64'd0);
    sendBytes(4, 4, 8'h30);
    endWrite(1'b1, 1'b0);
    check(loadPulse == 1'b0, "R6 second half alone", 64'(loadPulse), 64'd0);

    // R4: strobed but unacknowledged byte does not land
    sendBytes(0, 8, 8'hA0);
    byteStrobe = 1'b1; byteAddr = AW'(2); wrData = 8'hEE;
    cyc();
    byteStrobe = 1'b0;
    endWrite(1'b1, 1'b0);
    check(loadPulse == 1'b1, "R4 load present", 64'(loadPulse), 64'd1);
    check(loadData[23:16] == 8'hA2, "R4 unacked byte ignored", 64'(loadData[23:16]), 64'hA2);
    cyc();

    // R2 R3: read snapshot while live time moves
    rdMode = 1'b1;
    liveTime = 64'h0123456789ABCDEF; ackEvt = 1'b1;
    snapA = liveTime;
    cyc();
    ackEvt = 1'b0; liveTime = 64'hFEDCBA9876543210;
    for (int i = 0; i < NB; i++) begin
      byteAddr = AW'(i); #1;
      check(rdData == snapA[i*8 +: 8], "R2 snapshot byte", 64'(rdData), 64'(snapA[i*8 +: 8]));
    end
    ackEvt = 1'b1; liveTime = 64'h5555AAAA5555AAAA;
    cyc();
    ackEvt = 1'b0; byteAddr = AW'(5); #1;
    check(rdData == snapA[47:40], "R3 second ack keeps snapshot", 64'(rdData), 64'(snapA[47:40]));
    stopEvt = 1'b1;
    cyc();
    stopEvt = 1'b0;
    liveTime = 64'h0F1E2D3C4B5A6978; ackEvt = 1'b1;
    cyc();
    ackEvt = 1'b0; byteAddr = AW'(0); #1;
    check(rdData == 8'h78, "R3 new read recaptures", 64'(rdData), 64'h78);
    stopEvt = 1'b1;
    cyc();
    stopEvt = 1'b0; rdMode = 1'b0;

    // R9: free-running period
    sendBytes(0, 8, 8'h60);
    tickAt = -1;
    for (int i = 0; i < 2 * DIV && tickAt < 0; i++) begin
      if (secTick) tickAt = i;
      else cyc();
    end
    check(tickAt >= 0, "R9 tick seen", 64'(tickAt), 64'd0);
    begin
      int gap;
      gap = 0;
      cyc(); gap++;
      while (!secTick && gap < 2 * DIV) begin cyc(); gap++; end
      check(gap == DIV, "R9 free-run period", 64'(gap), 64'(DIV));
    end

    // R10: load coincides with prescaler end
    for (int i = 0; i < DIV - 1; i++) cyc();
    wrEnable = 1'b1; stopEvt = 1'b1;
    cyc();
    stopEvt = 1'b0;
    check(loadPulse == 1'b1, "R10 load present", 64'(loadPulse), 64'd1);
    check(secTick == 1'b0, "R10 tick suppressed in load cycle", 64'(secTick), 64'd0);
    check(loadData == expImage(8'h60), "R5 loadData at coincidence", loadData, expImage(8'h60));
    begin
      int ticks;
      ticks = 0;
      for (int k = 1; k <= DIV; k++) begin
        cyc();
        if (secTick) begin
          ticks++;
          check(k == DIV, "R9 first tick after load", 64'(k), 64'(DIV));
        end
      end
      check(ticks == 1, "R9 one tick in restart span", 64'(ticks), 64'd1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule